// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block arbitrates eight interrupt request lines for a processor. Each line has a pending bit in a request register. A mask register stops chosen lines from being forwarded. An in-service register records which interrupts the processor is currently handling. When an unmasked pending request has higher priority than everything in service, the block raises its interrupt output. When the processor acknowledges, the block moves that request into service and hands back a vector built from a programmable base and the line number. Software clears the service bit with an end-of-interrupt write.

Any line can be flagged as a cascade line. A second controller's interrupt output is wired to that line. A cascade line is sampled by level, not by edge. When the processor acknowledges a cascade line, the block does not return a vector. Instead it pulses an acknowledge towards the downstream controller, and that controller supplies the vector. Two instances chained this way give sixteen sources.

Registers are reached through a single-cycle write strobe and a combinational read port.

Top module: `irq8_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF (all lines masked). The vector base, cascade flags, request and in-service registers all read 0x00. int_o and vec_valid_o are low and casc_ack_o is zero.
- R2: A rising edge on a non-cascade line sets that line's request bit at the next clock edge. A level held high after acknowledge does not set the bit again.
- R3: A masked line still records its request bit but does not raise int_o. Clearing its mask bit raises int_o.
- R4: Among forwarded requests, the lowest line index wins.
- R5: An acknowledge while int_o is high returns, one clock later, vec_o = {base[7:3], line[2:0]} with vec_valid_o high for one cycle. The same edge clears the request bit and sets the in-service bit.
- R6: A pending request is forwarded only when its index is lower than every in-service index. Equal or lower priority waits.
- R7: Writing to address 3 is an end-of-interrupt. It clears only the lowest-indexed in-service bit, and the write data is ignored.
- R8: An acknowledge while int_o is low returns {base, 3'b111} with vec_valid_o. It changes neither the request register nor the in-service register.
- R9: A line whose cascade flag is set follows its input level. Its acknowledge pulses casc_ack_o at that bit for one cycle in place of vec_valid_o, and still sets its in-service bit.
- R10: A new rising edge that arrives in the same cycle as the acknowledge of that line leaves the request bit set. An end-of-interrupt and an acknowledge in the same cycle both take effect.
- R11: The register map is as follows. Address 0 is the mask, read/write. Address 1 is the vector base in bits 7:3, with bits 2:0 reading 0. Address 2 holds the cascade flags. Address 3 reads the request register and a write to it is an end-of-interrupt. Address 4 reads the in-service register. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, line 0 highest priority |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Processor acknowledge, one cycle per vector |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | vec_o is valid this cycle |
| casc_ack_o | output | 8 | Acknowledge passed to a downstream controller on a cascade line |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the acknowledge that clears a request bit and a new rising edge on that same line. The bench provokes this by dropping the line and then raising it in the cycle that carries the acknowledge. It passes when the request register still shows the bit afterwards. The second pair is an acknowledge and an end-of-interrupt write issued in one cycle. The bench sets up one bit in service with a higher-priority request pending, then issues both together. It passes when the in-service register holds only the newly acknowledged line.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
  typedef enum logic [2:0] {
    RA_MASK    = 3'd0,
    RA_BASE    = 3'd1,
    RA_CASC    = 3'd2,
    RA_REQ_EOI = 3'd3,
    RA_ISR     = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq8_prio_enc.sv
// Lowest set index wins.
module irq8_prio_enc #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq8_req_latch.sv
module irq8_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise;
    assign rise = irq_i[g] & ~prev_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         req_o[g] <= 1'b0;
      else if (level_i[g]) req_o[g] <= irq_i[g];
      else                 req_o[g] <= rise | (req_o[g] & ~clr_i[g]);  // new edge beats clear
    end
  end
endmodule

// File: rtl/irq8_service.sv
module irq8_service #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] low_bit;
  logic [N-1:0] clr;

  assign low_bit = isr_o & (~isr_o + N'(1));
  assign clr     = eoi_i ? low_bit : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr) | set_i;
  end
endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IDX_W,
  localparam int DATA_W = VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               int_o,
  input  logic               ack_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o,
  output logic [N_LINES-1:0] casc_ack_o
);
  logic [N_LINES-1:0] mask_q, casc_q;
  logic [BASE_W-1:0]  base_q;
  logic [N_LINES-1:0] req_w, isr_w, pend_w, take_w;
  logic               p_found, s_found, fwd, eoi_wr;
  logic [IDX_W-1:0]   p_idx, s_idx;

  assign eoi_wr = wr_en_i && (reg_addr_e'(addr_i) == RA_REQ_EOI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      base_q <= '0;
      casc_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(addr_i))
        RA_MASK: mask_q <= wdata_i[N_LINES-1:0];
        RA_BASE: base_q <= wdata_i[DATA_W-1:IDX_W];
        RA_CASC: casc_q <= wdata_i[N_LINES-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_MASK:    rdata_o = DATA_W'(mask_q);
      RA_BASE:    rdata_o = {base_q, {IDX_W{1'b0}}};
      RA_CASC:    rdata_o = DATA_W'(casc_q);
      RA_REQ_EOI: rdata_o = DATA_W'(req_w);
      RA_ISR:     rdata_o = DATA_W'(isr_w);
      default:    rdata_o = '0;
    endcase
  end

  irq8_req_latch #(.N(N_LINES)) u_req (
    .clk_i, .rst_ni, .irq_i,
    .level_i(casc_q), .clr_i(take_w), .req_o(req_w)
  );

  assign pend_w = req_w & ~mask_q;

  irq8_prio_enc #(.N(N_LINES)) u_pend_enc (.vec_i(pend_w), .found_o(p_found), .idx_o(p_idx));
  irq8_prio_enc #(.N(N_LINES)) u_isr_enc  (.vec_i(isr_w),  .found_o(s_found), .idx_o(s_idx));

  // fully nested: only strictly higher priority than any in-service bit
  assign fwd    = p_found && (!s_found || (p_idx < s_idx));
  assign int_o  = fwd;
  assign take_w = (ack_i && fwd) ? (N_LINES'(1) << p_idx) : '0;

  irq8_service #(.N(N_LINES)) u_isr (
    .clk_i, .rst_ni, .set_i(take_w), .eoi_i(eoi_wr), .isr_o(isr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      casc_ack_o  <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      casc_ack_o  <= '0;
      if (ack_i) begin
        if (fwd && casc_q[p_idx]) begin
          casc_ack_o <= take_w;
        end else begin
          vec_valid_o <= 1'b1;
          vec_o       <= {base_q, fwd ? p_idx : {IDX_W{1'b1}}};
        end
      end
    end
  end
endmodule

// File: rtl/irq8_ctrl_chk.sv
module irq8_ctrl_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               int_o,
  input logic               vec_valid_o,
  input logic [N_LINES-1:0] casc_ack_o,
  input logic [N_LINES-1:0] isr_w,
  input logic [N_LINES-1:0] mask_q,
  input logic               eoi_wr
);
  a_r1_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !int_o);

  a_r5_valid_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));

  a_r5_ack_enters_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o) |=> (isr_w != '0));

  a_r7_eoi_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !ack_i && isr_w != '0) |=> ($countones(isr_w) == $countones($past(isr_w)) - 1));

  a_r9_casc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(casc_ack_o));

  a_r9_casc_excl_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_o && (casc_ack_o != '0)));

  a_r8_idle_ack_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !eoi_wr) |=> $stable(isr_w));
endmodule

bind irq8_ctrl irq8_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i, .rst_ni, .ack_i, .int_o, .vec_valid_o, .casc_ack_o,
  .isr_w, .mask_q, .eoi_wr
);

// File: tb/irq8_ctrl_test.sv
`timescale 1ns/1ps
module irq8_ctrl_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] irq = '0, wdata = '0;
  logic       wr_en = 1'b0, ack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] rdata, vec, casc_ack;
  logic       int_w, vec_valid;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  localparam logic [7:0] BASE = 8'hA0;

  always #2.5 clk = ~clk;

  irq8_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .int_o(int_w), .ack_i(ack),
    .vec_o(vec), .vec_valid_o(vec_valid), .casc_ack_o(casc_ack)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop expected vectors as the design returns them
  always @(negedge clk) if (rst_ni && vec_valid) begin
    if (exp_q.size() == 0) chk("R5 unexpected vector", vec, 8'hxx);
    else chk("R5 vector", vec, exp_q.pop_front());
  end

  task automatic step(); @(negedge clk); endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    addr = a; #0.5; chk(tag, rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d; step(); wr_en = 1'b0;
  endtask

  task automatic do_ack(bit expect_vec, logic [7:0] v);
    if (expect_vec) exp_q.push_back(v);
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step(); rst_ni = 1'b1; step();
    // R1 reset state
    rd(3'd0, 8'hFF, "R1 mask"); rd(3'd1, 8'h00, "R1 base"); rd(3'd2, 8'h00, "R1 casc");
    rd(3'd3, 8'h00, "R1 req");  rd(3'd4, 8'h00, "R1 isr");
    chk("R1 int", {7'd0, int_w}, 8'h00); chk("R1 valid", {7'd0, vec_valid}, 8'h00);
    chk("R1 casc_ack", casc_ack, 8'h00);
    // R11 map
    wr(3'd1, 8'hA7); rd(3'd1, BASE, "R11 base low bits");
    rd(3'd6, 8'h00, "R11 unused addr");
    wr(3'd0, 8'h00); rd(3'd0, 8'h00, "R11 mask rw");
    // R2 / R5 basic
    irq[5] = 1'b1; step();
    rd(3'd3, 8'h20, "R2 edge sets req"); chk("R2 int", {7'd0, int_w}, 8'h01);
    do_ack(1, BASE | 8'd5);
    rd(3'd3, 8'h00, "R5 req cleared"); rd(3'd4, 8'h20, "R5 isr set");
    step(); rd(3'd3, 8'h00, "R2 held level no retrigger");
    // R6 nesting
    irq[6] = 1'b1; step(); chk("R6 lower blocked", {7'd0, int_w}, 8'h00);
    irq[1] = 1'b1; step(); chk("R6 higher passes", {7'd0, int_w}, 8'h01);
    do_ack(1, BASE | 8'd1); rd(3'd4, 8'h22, "R6 nested isr");
    // R7 EOI clears lowest index only
    wr(3'd3, 8'h55); rd(3'd4, 8'h20, "R7 eoi lowest");
    chk("R6 still blocked", {7'd0, int_w}, 8'h00);
    wr(3'd3, 8'h00); rd(3'd4, 8'h00, "R7 eoi second");
    chk("R6 released", {7'd0, int_w}, 8'h01);
    do_ack(1, BASE | 8'd6); wr(3'd3, 8'h00);
    // R4 priority
    irq = 8'h00; step();
    irq = 8'h88; step();
    do_ack(1, BASE | 8'd3); wr(3'd3, 8'h00);
    do_ack(1, BASE | 8'd7); wr(3'd3, 8'h00);
    rd(3'd4, 8'h00, "R4 isr empty");
    // R3 mask
    irq = 8'h00; wr(3'd0, 8'h10);
    irq[4] = 1'b1; step();
    rd(3'd3, 8'h10, "R3 masked still latched"); chk("R3 masked no int", {7'd0, int_w}, 8'h00);
    wr(3'd0, 8'h00); chk("R3 unmask int", {7'd0, int_w}, 8'h01);
    do_ack(1, BASE | 8'd4);
    // R10 ack + EOI same cycle: isr={4}, raise line 2
    irq[2] = 1'b1; step();
    wr_en = 1'b1; addr = 3'd3; wdata = 8'h00;
    do_ack(1, BASE | 8'd2); wr_en = 1'b0;
    rd(3'd4, 8'h04, "R10 ack and eoi together");
    wr(3'd3, 8'h00); rd(3'd4, 8'h00, "R10 isr clear");
    // R8 spurious ack
    chk("R8 idle", {7'd0, int_w}, 8'h00);
    do_ack(1, BASE | 8'd7);
    rd(3'd4, 8'h00, "R8 isr unchanged"); rd(3'd3, 8'h00, "R8 req unchanged");
    // R10 new edge during ack of same line
    irq = 8'h00; step();
    irq[0] = 1'b1; step();
    irq[0] = 1'b0; step();
    irq[0] = 1'b1; do_ack(1, BASE | 8'd0);
    rd(3'd3, 8'h01, "R10 edge beats clear"); rd(3'd4, 8'h01, "R10 isr");
    wr(3'd3, 8'h00); do_ack(1, BASE | 8'd0); wr(3'd3, 8'h00);
    // R9 cascade line 3
    irq = 8'h00; wr(3'd2, 8'h08); rd(3'd2, 8'h08, "R11 casc rw");
    irq[3] = 1'b1; step();
    rd(3'd3, 8'h08, "R9 level req");
    do_ack(0, 8'h00);
    chk("R9 casc_ack", casc_ack, 8'h08); chk("R9 no vector", {7'd0, vec_valid}, 8'h00);
    rd(3'd4, 8'h08, "R9 isr set");
    step(); chk("R9 casc pulse", casc_ack, 8'h00);
    rd(3'd3, 8'h08, "R9 level held"); chk("R9 blocked", {7'd0, int_w}, 8'h00);
    irq[3] = 1'b0; step(); rd(3'd3, 8'h00, "R9 level drop");
    wr(3'd3, 8'h00);
    step(); step();
    chk("R5 queue drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule